// File: doc/BRIEF.md
# Reconfigurable Broadcast/Serial Scan Controller

This block owns a fixed set of scan flip-flops cut into equal-length segments and runs a complete test session over them. In broadcast mode a single scan-in bit is fanned out to the head of every segment, so cells at the same depth receive the same stimulus and a pattern costs only one segment length of shifting. In serial mode multiplexers link each segment's tail to the next segment's head, so all flip-flops form one long chain and every cell can be set independently.

A session is started with two pattern counts. The controller runs the broadcast patterns first, then switches to serial patterns, and ends with a final unload. Each pattern is a shift phase followed by one capture cycle, during which the cells load the functional response presented on `cap_data`. Every bit that leaves a segment tail while shifting is folded into a 16-bit signature register. When both counts are spent, the controller raises `done` and freezes the signature until the next start. With one segment the structure is an ordinary full scan chain.

Top module: `bcast_scan_ctrl`

## Requirements
- R1: While reset is held and after it is released, `done`, `serial_mode`, `cap_en`, `signature` and all `seg_out` bits are 0.
- R2: On a broadcast shift cycle the depth-0 cell of every segment takes `scan_in`, every other cell takes the cell one depth nearer the head, and `seg_out[k]` is the deepest cell (depth SEGLEN-1) of segment k.
- R3: On a serial shift cycle the depth-0 cell of segment 0 takes `scan_in` and the depth-0 cell of segment k>0 takes `seg_out[k-1]`, so a `scan_in` bit reaches `seg_out[NSEG-1]` after NSEG*SEGLEN shifts; with NSEG=1 this is a plain chain.
- R4: A pattern is L shift cycles followed by exactly one capture cycle with `cap_en`=1 and no shifting; L is SEGLEN in broadcast and NSEG*SEGLEN in serial; two capture cycles are never adjacent.
- R5: The first `bc_patterns` patterns run in broadcast mode (`serial_mode`=0) and the following `sr_patterns` in serial mode (`serial_mode`=1); `serial_mode` changes only in the cycle after a capture cycle or an accepted start.
- R6: With `bc_patterns`=0 and `sr_patterns`>0, `serial_mode` is 1 from the first cycle after the start.
- R7: After the last capture, an unload of L shift cycles (L of the last pattern's mode) follows; `done` rises exactly bc*(SEGLEN+1)+sr*(NSEG*SEGLEN+1)+L cycles after the start edge and then stays 1 with no shift, no capture and a constant `signature` until the next start.
- R8: An accepted start clears `signature` to 0; on each shift cycle it becomes (sig<<1) XOR (0x100B if sig[15] was 1) XOR taps, where taps bit k is `seg_out[k]` before the shift and bits NSEG..15 are 0; otherwise it holds.
- R9: On a capture cycle segment k depth j loads `cap_data[k*SEGLEN+j]`.
- R10: `start` while a session is running (not idle, not done) has no effect.
- R11: With both counts 0, a start yields `done`=1 one cycle later with `signature`=0 and no shift or capture.
- R12: The counts are sampled only when a start is accepted; later changes on `bc_patterns` and `sr_patterns` have no effect on the running session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a session (accepted when idle or done) |
| scan_in | input | 1 | Single scan stimulus bit |
| bc_patterns | input | CW | Number of broadcast patterns |
| sr_patterns | input | CW | Number of serial patterns |
| cap_data | input | NSEG*SEGLEN | Functional response loaded on capture |
| cap_en | output | 1 | High during the capture cycle of a pattern |
| serial_mode | output | 1 | 1 when segments are joined into one chain |
| seg_out | output | NSEG | Tail bit of each segment |
| signature | output | 16 | Compacted response signature |
| done | output | 1 | Session complete, signature frozen |

## Verification
A wrong pattern or shift counter shows at the ports as a `cap_en` pulse one or more cycles early or late and as a `done` edge off the expected cycle total, visible at the first pattern boundary. A wrong link multiplexer or mode register shows on `seg_out` within one segment length, as segment tails that disagree with a chain model fed the same stimulus. A wrong signature feedback or tap mapping diverges on the first shift cycle whose top bit or tail bits are 1, and because the register never forgets, the error persists to `done`.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } bscan_state_e;

  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h100B;

  // one signature register step: shift, fold feedback, add taps
  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] cur,
                                                input logic [SIG_W-1:0] taps);
    logic [SIG_W-1:0] fb;
    fb = cur[SIG_W-1] ? SIG_POLY : '0;
    return {cur[SIG_W-2:0], 1'b0} ^ fb ^ taps;
  endfunction

  // shift length of one pattern in the given mode
  function automatic int unsigned pat_shift_len(input logic serial,
                                                input int unsigned seg_len,
                                                input int unsigned nseg);
    return serial ? seg_len * nseg : seg_len;
  endfunction

  // cycles from the start edge to the done edge
  function automatic int unsigned session_cycles(input int unsigned bc,
                                                 input int unsigned sr,
                                                 input int unsigned seg_len,
                                                 input int unsigned nseg);
    int unsigned unload;
    if (bc == 0 && sr == 0) return 0;
    unload = pat_shift_len(sr != 0, seg_len, nseg);
    return bc * (seg_len + 1) + sr * (seg_len * nseg + 1) + unload;
  endfunction

endpackage

// File: rtl/bscan_segment.sv
module bscan_segment #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           load_en,
  input  logic           din,
  input  logic [LEN-1:0] load_vec,
  output logic           dout
);

  logic [LEN-1:0] cells;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cells <= '0;
        else if (load_en)  cells <= load_vec;
        else if (shift_en) cells <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cells <= '0;
        else if (load_en)  cells <= load_vec;
        else if (shift_en) cells <= {cells[LEN-2:0], din};
      end
    end
  endgenerate

  assign dout = cells[LEN-1];

endmodule

// File: rtl/bscan_link_mux.sv
module bscan_link_mux #(
  parameter int NSEG = 4
) (
  input  logic            serial,
  input  logic            scan_in,
  input  logic [NSEG-1:0] tails,
  output logic [NSEG-1:0] heads
);

  assign heads[0] = scan_in;

  generate
    for (genvar k = 1; k < NSEG; k++) begin : g_link
      assign heads[k] = serial ? tails[k-1] : scan_in;
    end
  endgenerate

endmodule

// File: rtl/bscan_sig_reg.sv
module bscan_sig_reg
  import bscan_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [NSEG-1:0]  taps,
  output logic [SIG_W-1:0] sig
);

  logic [SIG_W-1:0] taps_wide;

  always_comb begin
    taps_wide = '0;
    taps_wide[NSEG-1:0] = taps;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (step)  sig <= sig_step(sig, taps_wide);
  end

endmodule

// File: rtl/bscan_seq_ctrl.sv
module bscan_seq_ctrl
  import bscan_pkg::*;
#(
  parameter int CW     = 16,
  parameter int SEGLEN = 8,
  parameter int NSEG   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] bc_cnt,
  input  logic [CW-1:0] sr_cnt,
  output logic          go,
  output logic          shift_now,
  output logic          cap_now,
  output logic          serial,
  output logic          fin
);

  localparam int NFF = NSEG * SEGLEN;
  localparam int LW  = $clog2(NFF + 1);
  localparam logic [LW-1:0] BC_RELOAD = LW'(pat_shift_len(1'b0, SEGLEN, NSEG) - 1);
  localparam logic [LW-1:0] SR_RELOAD = LW'(pat_shift_len(1'b1, SEGLEN, NSEG) - 1);

  bscan_state_e  state;
  logic [CW-1:0] bc_left, sr_left;
  logic [LW-1:0] shift_left;
  logic          bc_last, sr_last;

  assign go        = start && (state == ST_IDLE || state == ST_DONE);
  assign shift_now = (state == ST_SHIFT) || (state == ST_UNLOAD);
  assign cap_now   = (state == ST_CAPT);
  assign fin       = (state == ST_DONE);
  assign bc_last   = (bc_left == CW'(1));
  assign sr_last   = (sr_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      serial     <= 1'b0;
      bc_left    <= '0;
      sr_left    <= '0;
      shift_left <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            bc_left <= bc_cnt;
            sr_left <= sr_cnt;
            if (bc_cnt != '0) begin
              serial     <= 1'b0;
              state      <= ST_SHIFT;
              shift_left <= BC_RELOAD;
            end else if (sr_cnt != '0) begin
              serial     <= 1'b1;
              state      <= ST_SHIFT;
              shift_left <= SR_RELOAD;
            end else begin
              serial <= 1'b0;
              state  <= ST_DONE;
            end
          end
        end
        ST_SHIFT: begin
          if (shift_left == '0) state <= ST_CAPT;
          else                  shift_left <= shift_left - LW'(1);
        end
        ST_CAPT: begin
          if (!serial) begin
            bc_left <= bc_left - CW'(1);
            if (!bc_last) begin
              state      <= ST_SHIFT;
              shift_left <= BC_RELOAD;
            end else if (sr_left != '0) begin
              serial     <= 1'b1;
              state      <= ST_SHIFT;
              shift_left <= SR_RELOAD;
            end else begin
              state      <= ST_UNLOAD;
              shift_left <= BC_RELOAD;
            end
          end else begin
            sr_left <= sr_left - CW'(1);
            if (!sr_last) begin
              state      <= ST_SHIFT;
              shift_left <= SR_RELOAD;
            end else begin
              state      <= ST_UNLOAD;
              shift_left <= SR_RELOAD;
            end
          end
        end
        ST_UNLOAD: begin
          if (shift_left == '0) state <= ST_DONE;
          else                  shift_left <= shift_left - LW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcast_scan_ctrl.sv
module bcast_scan_ctrl
  import bscan_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int SEGLEN = 8,
  parameter int CW     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   scan_in,
  input  logic [CW-1:0]          bc_patterns,
  input  logic [CW-1:0]          sr_patterns,
  input  logic [NSEG*SEGLEN-1:0] cap_data,
  output logic                   cap_en,
  output logic                   serial_mode,
  output logic [NSEG-1:0]        seg_out,
  output logic [SIG_W-1:0]       signature,
  output logic                   done
);

  localparam int NFF = NSEG * SEGLEN;

  // named internal events, also observed by the bound checker
  logic            go;
  logic            shift_now;
  logic            cap_now;
  logic            serial;
  logic            fin;
  logic [NSEG-1:0] heads;

  bscan_seq_ctrl #(
    .CW    (CW),
    .SEGLEN(SEGLEN),
    .NSEG  (NSEG)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bc_cnt   (bc_patterns),
    .sr_cnt   (sr_patterns),
    .go       (go),
    .shift_now(shift_now),
    .cap_now  (cap_now),
    .serial   (serial),
    .fin      (fin)
  );

  bscan_link_mux #(
    .NSEG(NSEG)
  ) u_link (
    .serial (serial),
    .scan_in(scan_in),
    .tails  (seg_out),
    .heads  (heads)
  );

  generate
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      bscan_segment #(
        .LEN(SEGLEN)
      ) u_segment (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_now),
        .load_en (cap_now),
        .din     (heads[k]),
        .load_vec(cap_data[k*SEGLEN +: SEGLEN]),
        .dout    (seg_out[k])
      );
    end
  endgenerate

  bscan_sig_reg #(
    .NSEG(NSEG)
  ) u_sig (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(go),
    .step (shift_now),
    .taps (seg_out),
    .sig  (signature)
  );

  assign cap_en      = cap_now;
  assign serial_mode = serial;
  assign done        = fin;

endmodule

// File: rtl/bcast_scan_checker.sv
module bcast_scan_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] bc_patterns,
  input logic [CW-1:0] sr_patterns,
  input logic          go,
  input logic          cap_en,
  input logic          serial_mode,
  input logic [15:0]   signature,
  input logic          done
);

  // R5: mode only flips after a capture or an accepted start
  a_r5_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode != $past(serial_mode)) |-> ($past(cap_en) || $past(go)));

  // R5: once serial, stays serial until the next session
  a_r5_serial_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !go) |=> serial_mode);

  // R4: capture cycles are never adjacent
  a_r4_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !cap_en);

  // R6: no broadcast patterns means serial from the first cycle
  a_r6_zero_bc: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bc_patterns == '0 && sr_patterns != '0) |=> serial_mode);

  // R11: empty session finishes at once
  a_r11_zero_both: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bc_patterns == '0 && sr_patterns == '0) |=> (done && signature == 16'h0));

  // R8: start clears the signature
  a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (signature == 16'h0));

  // R7: done holds and freezes the signature until a start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && $stable(signature)));

  // R7: nothing is captured once done
  a_r7_no_capture_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cap_en);

endmodule

bind bcast_scan_ctrl bcast_scan_checker #(
  .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bc_patterns(bc_patterns),
  .sr_patterns(sr_patterns),
  .go         (go),
  .cap_en     (cap_en),
  .serial_mode(serial_mode),
  .signature  (signature),
  .done       (done)
);

// File: tb/bcast_scan_ctrl_bench.sv
module bcast_scan_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG   = 4;
  localparam int SEGLEN = 8;
  localparam int CW     = 16;
  localparam int NFF    = NSEG * SEGLEN;
  localparam logic [15:0] POLY = 16'h100B;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           scan_in = 1'b0;
  logic [CW-1:0]  bc_patterns = '0;
  logic [CW-1:0]  sr_patterns = '0;
  logic [NFF-1:0] cap_data = '0;
  logic           cap_en;
  logic           serial_mode;
  logic [NSEG-1:0] seg_out;
  logic [15:0]    signature;
  logic           done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [NFF-1:0] m_ff = '0;
  logic [15:0]    m_sig = '0;
  logic [31:0]    rng = 32'h1ACE_B00C;

  bcast_scan_ctrl #(
    .NSEG(NSEG), .SEGLEN(SEGLEN), .CW(CW)
  ) u_bcast_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
    .bc_patterns(bc_patterns), .sr_patterns(sr_patterns), .cap_data(cap_data),
    .cap_en(cap_en), .serial_mode(serial_mode), .seg_out(seg_out),
    .signature(signature), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rng_next(input logic [31:0] r);
    return {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
  endfunction

  function automatic logic [NSEG-1:0] m_tails(input logic [NFF-1:0] ff);
    logic [NSEG-1:0] t;
    for (int k = 0; k < NSEG; k++) t[k] = ff[k*SEGLEN + SEGLEN - 1];
    return t;
  endfunction

  // signature register written bit by bit from R8
  function automatic logic [15:0] m_sig_step(input logic [15:0] cur,
                                             input logic [NSEG-1:0] taps);
    logic [15:0] n;
    for (int i = 0; i < 16; i++) begin
      n[i] = (i > 0) ? cur[i-1] : 1'b0;
      if (cur[15] && POLY[i]) n[i] = ~n[i];
      if (i < NSEG && taps[i]) n[i] = ~n[i];
    end
    return n;
  endfunction

  // chain shift from R2 / R3
  function automatic logic [NFF-1:0] m_shift(input logic [NFF-1:0] ff,
                                             input bit ser, input logic sin);
    logic [NFF-1:0] n;
    for (int k = 0; k < NSEG; k++)
      for (int j = 0; j < SEGLEN; j++) begin
        int idx = k*SEGLEN + j;
        if (j != 0)           n[idx] = ff[idx-1];
        else if (ser && k > 0) n[idx] = ff[idx-1];
        else                  n[idx] = sin;
      end
    return n;
  endfunction

  task automatic new_stimulus();
    rng = rng_next(rng);
    scan_in = rng[3];
    rng = rng_next(rng);
    cap_data = {rng, rng_next(rng)} [NFF-1:0];
  endtask

  task automatic compare_state(input bit exp_cap, input bit exp_mode, input bit after_cap);
    string sreq;
    sreq = after_cap ? "R9" : (exp_mode ? "R3" : "R2");
    check(seg_out == m_tails(m_ff), sreq, 64'(seg_out), 64'(m_tails(m_ff)));
    check(signature == m_sig, "R8", 64'(signature), 64'(m_sig));
    check(cap_en == exp_cap, "R4", 64'(cap_en), 64'(exp_cap));
    check(serial_mode == exp_mode, exp_mode ? "R6/R5" : "R5", 64'(serial_mode), 64'(exp_mode));
    check(done == 1'b0, "R7", 64'(done), 64'd0);
  endtask

  // one session; poke>0 re-pulses start and scrambles the counts (R10, R12)
  task automatic run_session(input int bc, input int sr, input int poke);
    int n_pat;
    int cyc;
    bit mode;
    bit after_cap;
    logic sin_used;
    logic [NFF-1:0] cap_used;
    @(negedge clk);
    bc_patterns = CW'(bc);
    sr_patterns = CW'(sr);
    start = 1'b1;
    new_stimulus();
    @(posedge clk);
    m_sig = '0;
    @(negedge clk);
    start = 1'b0;
    n_pat = bc + sr;
    cyc = 0;
    after_cap = 0;
    if (n_pat == 0) begin
      check(done == 1'b1, "R11", 64'(done), 64'd1);
      check(signature == 16'h0, "R11", 64'(signature), 64'd0);
      check(seg_out == m_tails(m_ff), "R11", 64'(seg_out), 64'(m_tails(m_ff)));
      return;
    end
    for (int p = 0; p <= n_pat; p++) begin
      int len;
      bit unload;
      unload = (p == n_pat);
      if (!unload) mode = (p >= bc);
      len = mode ? NFF : SEGLEN;
      for (int s = 0; s <= len; s++) begin
        bit is_cap;
        is_cap = (s == len);
        if (is_cap && unload) break;
        compare_state(is_cap, mode, after_cap);
        sin_used = scan_in;
        cap_used = cap_data;
        cyc++;
        if (poke > 0 && cyc == poke) begin
          start = 1'b1;
          bc_patterns = CW'(bc + 3);
          sr_patterns = CW'(sr + 5);
        end
        @(posedge clk);
        if (is_cap) m_ff = cap_used;
        else begin
          m_sig = m_sig_step(m_sig, m_tails(m_ff));
          m_ff  = m_shift(m_ff, mode, sin_used);
        end
        after_cap = is_cap;
        @(negedge clk);
        start = 1'b0;
        new_stimulus();
      end
    end
    check(done == 1'b1, poke > 0 ? "R10/R12 done time" : "R7 done time", 64'(done), 64'd1);
    check(signature == m_sig, "R8 final", 64'(signature), 64'(m_sig));
    check(seg_out == m_tails(m_ff), "R7 unload", 64'(seg_out), 64'(m_tails(m_ff)));
    for (int h = 0; h < 5; h++) begin
      @(negedge clk);
      new_stimulus();
      check(done == 1'b1, "R7 hold", 64'(done), 64'd1);
      check(signature == m_sig, "R7 frozen", 64'(signature), 64'(m_sig));
      check(cap_en == 1'b0, "R7 idle", 64'(cap_en), 64'd0);
      check(seg_out == m_tails(m_ff), "R7 no shift", 64'(seg_out), 64'(m_tails(m_ff)));
    end
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 2);
    check(done == 1'b0, "R1", 64'(done), 64'd0);
    check(serial_mode == 1'b0, "R1", 64'(serial_mode), 64'd0);
    check(cap_en == 1'b0, "R1", 64'(cap_en), 64'd0);
    check(signature == 16'h0, "R1", 64'(signature), 64'd0);
    check(seg_out == '0, "R1", 64'(seg_out), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && cap_en == 1'b0, "R1 after release", 64'({done, cap_en}), 64'd0);
  endtask

  task automatic t_broadcast_only(); run_session(2, 0, 0); endtask // R2 R4 R7
  task automatic t_mixed_busy_start(); run_session(3, 2, 20); endtask // R5 R10 R12
  task automatic t_serial_only(); run_session(0, 2, 0); endtask // R3 R6
  task automatic t_empty(); run_session(0, 0, 0); endtask // R11
  task automatic t_one_each(); run_session(1, 1, 0); endtask // R5 R9

  initial begin
    t_reset();
    t_broadcast_only();
    t_mixed_busy_start();
    t_serial_only();
    t_empty();
    t_one_each();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule